// File: doc/BRIEF.md
# Core Timer with Real-Time and Overflow Interrupts

This block is an 8-bit free-running timer. It advances by one on each clock where the count-enable input is high; a prescaler outside the block drives that input. Two events come from the counter. The first is an overflow, when the count wraps from 0xFF to 0x00. The second is a real-time tick, when the count reaches a multiple of a programmable power-of-two period. Each event sets its own sticky flag.

One control/status byte holds both flags, an enable for each flag and a two-bit period selector. Software writes this byte to set the enables and the period, and to clear flags. The count and the status byte are both visible at the ports. There is a single interrupt output. It is high while either flag is set together with its enable, so both sources share one service routine.

Top module: `ctimer_top`

## Requirements
- R1: After reset the count is 0x00 and the status byte is 0x00: both flags, both enables and the period field are clear. The interrupt output is low.
- R2: On a clock where `tick_en` is high, the count advances by one modulo 256. Otherwise it holds its value.
- R3: The overflow flag (status bit 7) sets on the clock where the count advances from 0xFF to 0x00.
- R4: The real-time flag (status bit 6) sets on the clock where an advance brings the count to a multiple of 2^(n+4). Here n is the period field, status bits 1:0, with a value from 0 to 3.
- R5: A write with 0 in bit 7 or bit 6 clears the matching flag. A write with 1 in that bit leaves the flag as it was.
- R6: If a flag's event occurs in the same clock as a write that clears it, the flag ends up set.
- R7: Every write loads the overflow enable (bit 5), the real-time enable (bit 4) and the period field (bits 1:0) from the write data. Bits 3:2 always read 0.
- R8: `irq` equals (bit 7 AND bit 5) OR (bit 6 AND bit 4) of the status byte, in the same cycle.
- R9: Flags set whether or not their enable is set. A flag whose enable is clear does not drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count enable from the prescaler |
| csr_we | input | 1 | Write strobe for the control/status byte |
| csr_wdata | input | 8 | Write data for the control/status byte |
| csr_rdata | output | 8 | Current control/status byte |
| count_q | output | 8 | Current count |
| irq | output | 1 | Combined timer interrupt request |

## Verification
The bench drives the count across 0xFF at every period setting. A design that misses the wrap would never raise the overflow flag, and one that decodes the wrong counter tap would raise the real-time flag at the wrong multiples. It also changes the period field between ticks, so a tap that lags the field by one clock would show up. It puts a clearing write in the same clock as a flag event; a design that lets the clear win would lose that event. Random writes with 1 in the flag bits check that a design which treats the written value as data would wrongly set or drop flags. Random enable patterns catch an interrupt that ignores its mask, or a flag that is only raised while it is enabled.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;

  // Field positions inside the control/status byte
  localparam int OVF_FLAG_BIT = 7;
  localparam int RT_FLAG_BIT  = 6;
  localparam int OVF_EN_BIT   = 5;
  localparam int RT_EN_BIT    = 4;
  localparam int RATE_LSB     = 0;

  // Source indices for the per-flag generate loop
  localparam int SRC_RT   = 0;
  localparam int SRC_OVF  = 1;
  localparam int NUM_SRC  = 2;

  typedef struct packed {
    logic ovf;
    logic rt;
  } ctimer_evt_t;

endpackage

// File: rtl/ctimer_counter.sv
module ctimer_counter
  import ctimer_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int SEL_W   = 2,
  parameter int RT_BASE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] rate_sel,
  output logic [CNT_W-1:0] count_q,
  output ctimer_evt_t      evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // The real-time tap is hit when the low (rate+RT_BASE) bits are all ones,
  // so the next advance lands on a multiple of the period.
  function automatic logic rt_tap_hit(input logic [CNT_W-1:0] cnt,
                                      input logic [SEL_W-1:0] rate);
    logic [CNT_W-1:0] mask;
    mask = CNT_W'((1 << (int'(rate) + RT_BASE)) - 1);
    return (cnt & mask) == mask;
  endfunction

  logic ovf_hit;
  logic rt_hit;

  assign ovf_hit = tick_en && (count_q == CNT_MAX);
  assign rt_hit  = tick_en && rt_tap_hit(count_q, rate_sel);

  assign evt.ovf = ovf_hit;
  assign evt.rt  = rt_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else if (tick_en) count_q <= count_q + 1'b1;
  end

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (count_q - $past(count_q)) == CNT_W'(1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count_q));

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt.ovf |=> count_q == '0);

  assert_rt_lsb_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rt |=> count_q[RT_BASE-1:0] == '0);

endmodule

// File: rtl/ctimer_flag.sv
module ctimer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_q
);

  // A set event beats a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !flag_q);

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && flag_q) |=> flag_q);

endmodule

// File: rtl/ctimer_ctrl.sv
module ctimer_ctrl
  import ctimer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic              ovf_en,
  output logic              rt_en,
  output logic [SEL_W-1:0]  rate_sel,
  output logic [NUM_SRC-1:0] clr_vec
);

  // Writing 0 to a flag bit requests a clear; writing 1 requests nothing.
  assign clr_vec[SRC_OVF] = csr_we && !csr_wdata[OVF_FLAG_BIT];
  assign clr_vec[SRC_RT]  = csr_we && !csr_wdata[RT_FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_en   <= 1'b0;
      rt_en    <= 1'b0;
      rate_sel <= '0;
    end else if (csr_we) begin
      ovf_en   <= csr_wdata[OVF_EN_BIT];
      rt_en    <= csr_wdata[RT_EN_BIT];
      rate_sel <= csr_wdata[RATE_LSB +: SEL_W];
    end
  end

  assert_en_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |=> (ovf_en == $past(csr_wdata[OVF_EN_BIT])) &&
               (rt_en == $past(csr_wdata[RT_EN_BIT])));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_we |=> $stable(rate_sel) && $stable(ovf_en) && $stable(rt_en));

endmodule

// File: rtl/ctimer_top.sv
module ctimer_top
  import ctimer_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int SEL_W   = 2,
  parameter int RT_BASE = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic [CNT_W-1:0]  count_q,
  output logic              irq
);

  ctimer_evt_t        evt;
  logic               ovf_en;
  logic               rt_en;
  logic [SEL_W-1:0]   rate_sel;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] flag_vec;
  logic [NUM_SRC-1:0] en_vec;
  logic               ovf_req;
  logic               rt_req;

  ctimer_counter #(
    .CNT_W  (CNT_W),
    .SEL_W  (SEL_W),
    .RT_BASE(RT_BASE)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .rate_sel(rate_sel),
    .count_q (count_q),
    .evt     (evt)
  );

  ctimer_ctrl #(
    .DATA_W(DATA_W),
    .SEL_W (SEL_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_we   (csr_we),
    .csr_wdata(csr_wdata),
    .ovf_en   (ovf_en),
    .rt_en    (rt_en),
    .rate_sel (rate_sel),
    .clr_vec  (clr_vec)
  );

  assign set_vec[SRC_OVF] = evt.ovf;
  assign set_vec[SRC_RT]  = evt.rt;
  assign en_vec[SRC_OVF]  = ovf_en;
  assign en_vec[SRC_RT]   = rt_en;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    ctimer_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_evt(set_vec[g]),
      .clr_req(clr_vec[g]),
      .flag_q (flag_vec[g])
    );
  end

  // Named per-source requests, kept visible for the checks below
  assign ovf_req = flag_vec[SRC_OVF] && en_vec[SRC_OVF];
  assign rt_req  = flag_vec[SRC_RT]  && en_vec[SRC_RT];
  assign irq     = ovf_req || rt_req;

  always_comb begin
    csr_rdata = '0;
    csr_rdata[OVF_FLAG_BIT]           = flag_vec[SRC_OVF];
    csr_rdata[RT_FLAG_BIT]            = flag_vec[SRC_RT];
    csr_rdata[OVF_EN_BIT]             = ovf_en;
    csr_rdata[RT_EN_BIT]              = rt_en;
    csr_rdata[RATE_LSB +: SEL_W]      = rate_sel;
  end

  assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_rdata[OVF_EN_BIT] && !csr_rdata[RT_EN_BIT]) |-> !irq);

  assert_flag_ungated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt.ovf |=> csr_rdata[OVF_FLAG_BIT]);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_vec != '0));

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[3:2] == 2'b00);

endmodule

// File: tb/ctimer_top_tb.sv
`timescale 1ns/1ps
module ctimer_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       csr_we = 1'b0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic [7:0] count_q;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference state
  logic [7:0] m_cnt;
  logic       m_ovf, m_rt, m_ovf_en, m_rt_en;
  logic [1:0] m_rate;

  always #2 clk = ~clk;

  ctimer_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .count_q(count_q), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {m_ovf, m_rt, m_ovf_en, m_rt_en, 2'b00, m_rate};
  endfunction

  // Real-time event: the new count is a whole multiple of the period
  function automatic logic rt_due(input logic [7:0] cnt, input logic [1:0] rate);
    int period;
    period = 16 << rate;
    return ((int'(cnt) + 1) % period) == 0;
  endfunction

  function automatic logic exp_irq();
    return (m_ovf & m_ovf_en) | (m_rt & m_rt_en);
  endfunction

  task automatic compare_all();
    check("R2 count", count_q, m_cnt);
    check("R3/R4/R5/R6/R7 status", csr_rdata, exp_status());
    check("R8/R9 irq", irq, exp_irq());
  endtask

  // One clock: drive at negedge, update model, compare after posedge
  task automatic step(input logic t, input logic we, input logic [7:0] wd);
    logic ev_ovf, ev_rt;
    @(negedge clk);
    tick_en = t; csr_we = we; csr_wdata = wd;
    ev_ovf = t && (m_cnt == 8'hFF);
    ev_rt  = t && rt_due(m_cnt, m_rate);
    @(posedge clk);
    #1;
    m_ovf = ev_ovf | (m_ovf & !(we & !wd[7]));
    m_rt  = ev_rt  | (m_rt  & !(we & !wd[6]));
    if (we) begin
      m_ovf_en = wd[5]; m_rt_en = wd[4]; m_rate = wd[1:0];
    end
    if (t) m_cnt = m_cnt + 8'd1;
    compare_all();
  endtask

  task automatic run_to(input logic [7:0] target);
    while (m_cnt != target) step(1'b1, 1'b0, 8'h00);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    m_cnt = '0; m_ovf = 0; m_rt = 0; m_ovf_en = 0; m_rt_en = 0; m_rate = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 count", count_q, 8'h00);
    check("R1 status", csr_rdata, 8'h00);
    check("R1 irq", irq, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R9: both flags set with enables off, no irq
    run_to(8'hFF);
    step(1'b1, 1'b0, 8'h00);
    check("R3 ovf flag after wrap", csr_rdata[7], 1'b1);
    check("R9 masked irq", irq, 1'b0);

    // R8: enable overflow only, keep flags (1 in flag bits)
    step(1'b0, 1'b1, 8'hE0);
    check("R8 irq from ovf", irq, 1'b1);
    // R5: write 0 to both flags
    step(1'b0, 1'b1, 8'h30);
    check("R5 flags cleared", csr_rdata[7:6], 2'b00);

    // R4 at each period setting, R6 collision with clear
    for (int n = 0; n < 4; n++) begin
      step(1'b0, 1'b1, 8'h10 | 8'(n));
      run_to(8'(((16 << n) - 1) & 8'hFF));
      step(1'b1, 1'b1, 8'h10 | 8'(n)); // event and clear in same clock
      check("R6 rt set beats clear", csr_rdata[6], 1'b1);
      check("R4 rt irq", irq, 1'b1);
      step(1'b0, 1'b1, 8'h00 | 8'(n));
    end

    // R6 for overflow flag
    run_to(8'hFF);
    step(1'b1, 1'b1, 8'h20);
    check("R6 ovf set beats clear", csr_rdata[7], 1'b1);

    // R7 reserved bits
    step(1'b0, 1'b1, 8'hFF);
    check("R7 reserved read zero", csr_rdata[3:2], 2'b00);

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      logic t, we;
      logic [7:0] wd;
      t  = ($urandom_range(0, 9) < 7);
      we = ($urandom_range(0, 19) == 0);
      wd = 8'($urandom);
      if ($urandom_range(0, 1) == 1) wd[7:6] = 2'b11;
      step(t, we, wd);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule